// File: doc/BRIEF.md
# Status Word Store Execute Stage

This block is the execute stage for the legacy instruction that copies the low part of the main control register (the machine status word) into a general-purpose register or into memory. An earlier stage decodes the instruction and computes the address. It presents the opcode bytes, the ModRM reg field, the destination kind, the prefixes, the operand size, the processor mode and the privilege level. It also presents the control-register value, the user-mode-prevention bit and a set of precomputed segment, canonical, paging and alignment check results.

On a valid strobe the stage registers its result and presents it one cycle later with a done pulse. The result takes one of three forms: a register write with a byte-lane mask, a 16-bit memory write, or exactly one exception code. The width of a register result depends on the operand size and on whether the core runs in 64-bit mode. A memory result is always 16 bits. Faults follow a fixed priority, and any fault suppresses the write. The stage has no output that could change the arithmetic flags.

Top module: `msw_store_stage`

## Requirements
- R1: A synchronous reset clears `done`, `exc_valid`, `reg_we` and `mem_we`. Every cycle in which `in_valid` is high produces a one-cycle `done` pulse on the following cycle, and `done` stays low otherwise.
- R2: The instruction matches only when `op_b0`=0x0F, `op_b1`=0x01 and `modrm_reg`=4. A strobe that does not match still gives `done`, but gives no write and no exception.
- R3: With a memory destination (`rm_is_mem`=1) and no fault, `mem_we` is 1 and `mem_data` equals `ctl_word[15:0]` for every operand size. The operand-size encoding is 0=16, 1=32, 2=64 and 3 is treated as 16. `reg_we` is 0.
- R4: A 16-bit register destination receives `ctl_word[15:0]` in `reg_data[15:0]`, with `reg_mask`=0x03.
- R5: In 64-bit mode (`cpu_mode`=3), a 32-bit register destination receives `ctl_word[31:0]` zero-extended, with mask 0x0F. A 64-bit register destination receives all of `ctl_word`, with mask 0xFF.
- R6: Outside 64-bit mode, a 32-bit or 64-bit operand size writes `ctl_word[15:0]` into the low half, with mask 0x0F. The upper half is unspecified by the architecture and is driven as zero.
- R7: A LOCK prefix gives the invalid-opcode exception (code 1) and no write.
- R8: The general-protection fault (code 2) is raised when `umip`=1 and `cpl`>0 in protected mode (`cpu_mode`=1) or in 64-bit mode. In virtual-8086 mode (`cpu_mode`=2), `umip`=1 alone raises it. In real mode (`cpu_mode`=0) `umip` has no effect.
- R9: These checks apply only to a memory destination. In protected mode, a non-writable segment, a null selector or a data-segment limit violation gives code 2. In real and virtual-8086 mode only the data-limit violation gives code 2. Outside 64-bit mode, a stack-limit violation gives the stack fault (code 3). In 64-bit mode, `noncanon` gives code 2, `noncanon_stack` gives code 3, and the segment flags are ignored. Code 2 wins over code 3.
- R10: A memory destination with `page_fault`=1 gives the page-fault exception (code 4) in every mode except real mode, where the input is ignored.
- R11: The alignment-check exception (code 5) requires a memory destination, `ac_en`=1 and `misaligned`=1. It also requires `cpl`=3 in protected and 64-bit mode, and no privilege condition in virtual-8086 mode. It never occurs in real mode.
- R12: The exception priority is 1, then the privilege fault, then the segment/canonical faults (2 before 3), then 4, then 5. Exactly one code is reported, and while `exc_valid` is high neither write enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Decoded instruction present |
| op_b0 | input | 8 | First opcode byte |
| op_b1 | input | 8 | Second opcode byte |
| modrm_reg | input | 3 | ModRM reg field |
| rm_is_mem | input | 1 | Destination is memory (1) or register (0) |
| lock_pfx | input | 1 | LOCK prefix present |
| opsize | input | 2 | Operand size: 0=16, 1=32, 2=64, 3 as 16 |
| cpu_mode | input | 2 | 0 real, 1 protected/compat, 2 virtual-8086, 3 64-bit |
| cpl | input | 2 | Current privilege level |
| umip | input | 1 | User-mode instruction prevention bit |
| ac_en | input | 1 | Alignment checking enabled |
| misaligned | input | 1 | Memory reference is unaligned |
| seg_nonwritable | input | 1 | Destination segment not writable |
| seg_null | input | 1 | Data segment register holds a null selector |
| seg_limit_data | input | 1 | Data-segment limit violated |
| seg_limit_stack | input | 1 | Stack-segment limit violated |
| noncanon | input | 1 | Non-canonical address (64-bit mode) |
| noncanon_stack | input | 1 | Non-canonical address via stack segment (64-bit mode) |
| page_fault | input | 1 | Page walk reported a fault |
| ctl_word | input | CW | Control register value |
| done | output | 1 | Result valid pulse |
| reg_we | output | 1 | Register write enable |
| reg_data | output | CW | Register write data |
| reg_mask | output | CW/8 | Byte-lane write mask |
| mem_we | output | 1 | 16-bit memory write enable |
| mem_data | output | 16 | Memory write data |
| exc_valid | output | 1 | Exception reported |
| exc_code | output | 3 | 1 UD, 2 GP, 3 SS, 4 PF, 5 AC |

## Verification
The hardest cases to reach are the priority orderings. Each needs several fault inputs asserted at once while the mode and privilege level make exactly the intended subset of them eligible. The directed tasks stack the faults pairwise: a LOCK prefix over everything else, a privilege fault over segment faults, and a stack fault over a page fault. They also include a page fault together with an alignment fault. The mode-gated cases run the same fault input across several modes, so that an ignored input in one mode is seen as a completed write at the ports. One such case is a null selector in virtual-8086 mode.

// File: rtl/msw_store_stage.sv
module msw_store_stage #(
  parameter int CW = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [7:0]      op_b0,
  input  logic [7:0]      op_b1,
  input  logic [2:0]      modrm_reg,
  input  logic            rm_is_mem,
  input  logic            lock_pfx,
  input  logic [1:0]      opsize,
  input  logic [1:0]      cpu_mode,
  input  logic [1:0]      cpl,
  input  logic            umip,
  input  logic            ac_en,
  input  logic            misaligned,
  input  logic            seg_nonwritable,
  input  logic            seg_null,
  input  logic            seg_limit_data,
  input  logic            seg_limit_stack,
  input  logic            noncanon,
  input  logic            noncanon_stack,
  input  logic            page_fault,
  input  logic [CW-1:0]   ctl_word,
  output logic            done,
  output logic            reg_we,
  output logic [CW-1:0]   reg_data,
  output logic [CW/8-1:0] reg_mask,
  output logic            mem_we,
  output logic [15:0]     mem_data,
  output logic            exc_valid,
  output logic [2:0]      exc_code
);
  localparam int MW = CW / 8;
  localparam logic [2:0] X_NONE = 3'd0, X_UD = 3'd1, X_GP = 3'd2,
                         X_SS = 3'd3, X_PF = 3'd4, X_AC = 3'd5;

  wire hit     = (op_b0 == 8'h0F) && (op_b1 == 8'h01) && (modrm_reg == 3'd4);
  wire m_real  = (cpu_mode == 2'd0);
  wire m_prot  = (cpu_mode == 2'd1);
  wire m_v86   = (cpu_mode == 2'd2);
  wire m_long  = (cpu_mode == 2'd3);

  wire f_priv  = umip && (m_v86 || ((m_prot || m_long) && cpl != 2'd0));
  wire f_gp    = rm_is_mem && (m_long ? noncanon
                 : (seg_limit_data || (m_prot && (seg_nonwritable || seg_null))));
  wire f_ss    = rm_is_mem && (m_long ? noncanon_stack : seg_limit_stack);
  wire f_pf    = rm_is_mem && !m_real && page_fault;
  wire f_ac    = rm_is_mem && !m_real && ac_en && misaligned && (m_v86 || cpl == 2'd3);

  logic [2:0]    code_n;
  logic [CW-1:0] rdata_n;
  logic [MW-1:0] rmask_n;

  always_comb begin
    if (lock_pfx)    code_n = X_UD;
    else if (f_priv) code_n = X_GP;
    else if (f_gp)   code_n = X_GP;
    else if (f_ss)   code_n = X_SS;
    else if (f_pf)   code_n = X_PF;
    else if (f_ac)   code_n = X_AC;
    else             code_n = X_NONE;
  end

  always_comb begin
    rdata_n = '0;
    rmask_n = '0;
    rmask_n[1:0] = 2'b11;
    rdata_n[15:0] = ctl_word[15:0];
    if (opsize == 2'd1 || opsize == 2'd2) begin
      rmask_n[3:0] = 4'hF;
      if (m_long) rdata_n[31:0] = ctl_word[31:0];
    end
    if (opsize == 2'd2 && m_long) begin
      rmask_n = '1;
      rdata_n = ctl_word;
    end
  end

  wire go    = in_valid && hit;
  wire clean = go && (code_n == X_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      reg_we    <= 1'b0;
      mem_we    <= 1'b0;
      exc_valid <= 1'b0;
      exc_code  <= X_NONE;
      reg_data  <= '0;
      reg_mask  <= '0;
      mem_data  <= '0;
    end else begin
      done      <= in_valid;
      exc_valid <= go && (code_n != X_NONE);
      exc_code  <= go ? code_n : X_NONE;
      reg_we    <= clean && !rm_is_mem;
      mem_we    <= clean && rm_is_mem;
      if (in_valid) begin
        reg_data <= rdata_n;
        reg_mask <= rmask_n;
        mem_data <= ctl_word[15:0];
      end
    end
  end

  assert_done_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> done);
  assert_nohit_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !hit) |=> (!reg_we && !mem_we && !exc_valid));
  assert_memdata_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_data == $past(ctl_word[15:0])));
  assert_lock_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hit && lock_pfx) |=> (exc_valid && exc_code == X_UD && !reg_we && !mem_we));
  assert_umip_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hit && !lock_pfx && umip && m_v86) |=> (exc_code == X_GP));
  assert_suppress_R12: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (!reg_we && !mem_we && exc_code != X_NONE));
  assert_onewrite_R12: assert property (@(posedge clk) disable iff (rst)
    $countones({reg_we, mem_we, exc_valid}) <= 1);
endmodule

// File: tb/test_msw_store_stage.sv
`timescale 1ns/1ps
module test_msw_store_stage;
  localparam logic [63:0] CWV = 64'hA5A5_1234_8000_0033;

  logic clk = 0, rst = 1, in_valid = 0;
  logic [7:0] op_b0, op_b1;
  logic [2:0] modrm_reg;
  logic rm_is_mem, lock_pfx, umip, ac_en, misaligned;
  logic seg_nonwritable, seg_null, seg_limit_data, seg_limit_stack;
  logic noncanon, noncanon_stack, page_fault;
  logic [1:0] opsize, cpu_mode, cpl;
  logic [63:0] ctl_word;
  logic done, reg_we, mem_we, exc_valid;
  logic [63:0] reg_data;
  logic [7:0] reg_mask;
  logic [15:0] mem_data;
  logic [2:0] exc_code;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  msw_store_stage #(.CW(64)) i_msw_store_stage (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic defaults();
    op_b0 = 8'h0F; op_b1 = 8'h01; modrm_reg = 3'd4;
    rm_is_mem = 0; lock_pfx = 0; umip = 0; ac_en = 0; misaligned = 0;
    seg_nonwritable = 0; seg_null = 0; seg_limit_data = 0; seg_limit_stack = 0;
    noncanon = 0; noncanon_stack = 0; page_fault = 0;
    opsize = 2'd0; cpu_mode = 2'd1; cpl = 2'd0; ctl_word = CWV;
  endtask

  task automatic issue();
    @(negedge clk); in_valid = 1;
    @(negedge clk); in_valid = 0;
  endtask

  task automatic want_exc(input string req, input logic [2:0] code);
    issue();
    chk(req, {61'd0, done, exc_valid, reg_we | mem_we}, 64'b110);
    chk(req, exc_code, code);
    defaults();
  endtask

  task automatic want_mem(input string req);
    issue();
    chk(req, {61'd0, mem_we, reg_we, exc_valid}, 64'b100);
    chk(req, mem_data, CWV[15:0]);
    defaults();
  endtask

  task automatic want_reg(input string req, input logic [63:0] dmask, input logic [63:0] d, input logic [7:0] m);
    issue();
    chk(req, {61'd0, reg_we, mem_we, exc_valid}, 64'b100);
    chk(req, reg_data & dmask, d);
    chk(req, reg_mask, m);
    defaults();
  endtask

  task automatic t_reset();
    chk("R1 reset", {60'd0, done, exc_valid, reg_we, mem_we}, 64'd0);
    issue();
    chk("R1 done pulse", done, 1);
    @(negedge clk);
    chk("R1 done clears", done, 0);
  endtask

  task automatic t_nohit();
    op_b1 = 8'h00; issue();
    chk("R2 byte mismatch", {60'd0, done, reg_we, mem_we, exc_valid}, 64'b1000);
    defaults(); modrm_reg = 3'd3; lock_pfx = 1; issue();
    chk("R2 reg mismatch", {60'd0, done, reg_we, mem_we, exc_valid}, 64'b1000);
    defaults();
  endtask

  task automatic t_mem();
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++) begin
        rm_is_mem = 1; cpu_mode = m[1:0]; opsize = s[1:0];
        want_mem("R3 mem 16-bit");
      end
  endtask

  task automatic t_regs();
    opsize = 0; want_reg("R4 reg16", 64'hFFFF, 64'h0033, 8'h03);
    opsize = 0; cpu_mode = 3; want_reg("R4 reg16 long", 64'hFFFF, 64'h0033, 8'h03);
    opsize = 1; cpu_mode = 3; want_reg("R5 reg32 long", '1, 64'h8000_0033, 8'h0F);
    opsize = 2; cpu_mode = 3; want_reg("R5 reg64 long", '1, CWV, 8'hFF);
    opsize = 1; cpu_mode = 1; want_reg("R6 reg32 legacy", 64'hFFFF, 64'h0033, 8'h0F);
    opsize = 1; cpu_mode = 0; want_reg("R6 reg32 real", 64'hFFFF, 64'h0033, 8'h0F);
  endtask

  task automatic t_lock();
    lock_pfx = 1; want_exc("R7 lock reg", 3'd1);
    lock_pfx = 1; rm_is_mem = 1; cpu_mode = 0; want_exc("R7 lock mem real", 3'd1);
  endtask

  task automatic t_umip();
    umip = 1; cpl = 3; want_exc("R8 prot cpl3", 3'd2);
    umip = 1; cpl = 1; cpu_mode = 3; want_exc("R8 long cpl1", 3'd2);
    umip = 1; cpl = 0; want_reg("R8 prot cpl0", 64'hFFFF, 64'h0033, 8'h03);
    umip = 1; cpl = 0; cpu_mode = 2; want_exc("R8 v86", 3'd2);
    umip = 1; cpl = 3; cpu_mode = 0; want_reg("R8 real ignored", 64'hFFFF, 64'h0033, 8'h03);
  endtask

  task automatic t_seg();
    rm_is_mem = 1; seg_nonwritable = 1; want_exc("R9 nonwritable", 3'd2);
    rm_is_mem = 1; seg_null = 1; want_exc("R9 null", 3'd2);
    rm_is_mem = 1; seg_limit_data = 1; cpu_mode = 0; want_exc("R9 real data limit", 3'd2);
    rm_is_mem = 1; seg_limit_stack = 1; want_exc("R9 stack limit", 3'd3);
    rm_is_mem = 1; seg_limit_stack = 1; seg_null = 1; want_exc("R9 gp over ss", 3'd2);
    rm_is_mem = 1; seg_null = 1; cpu_mode = 2; want_mem("R9 v86 null ignored");
    seg_nonwritable = 1; seg_limit_stack = 1; want_reg("R9 reg ignores seg", 64'hFFFF, 64'h0033, 8'h03);
    rm_is_mem = 1; cpu_mode = 3; noncanon_stack = 1; want_exc("R9 long noncanon stack", 3'd3);
    rm_is_mem = 1; cpu_mode = 3; noncanon = 1; want_exc("R9 long noncanon", 3'd2);
    rm_is_mem = 1; cpu_mode = 3; seg_limit_data = 1; seg_null = 1; want_mem("R9 long ignores seg");
  endtask

  task automatic t_pf();
    rm_is_mem = 1; page_fault = 1; cpu_mode = 2; want_exc("R10 v86 pf", 3'd4);
    rm_is_mem = 1; page_fault = 1; cpu_mode = 3; want_exc("R10 long pf", 3'd4);
    rm_is_mem = 1; page_fault = 1; cpu_mode = 0; want_mem("R10 real ignored");
  endtask

  task automatic t_ac();
    rm_is_mem = 1; ac_en = 1; misaligned = 1; cpl = 3; want_exc("R11 cpl3", 3'd5);
    rm_is_mem = 1; ac_en = 1; misaligned = 1; cpl = 2; want_mem("R11 cpl2 none");
    rm_is_mem = 1; ac_en = 0; misaligned = 1; cpl = 3; want_mem("R11 disabled");
    rm_is_mem = 1; ac_en = 1; misaligned = 1; cpl = 0; cpu_mode = 2; want_exc("R11 v86", 3'd5);
    rm_is_mem = 1; ac_en = 1; misaligned = 1; cpl = 3; cpu_mode = 0; want_mem("R11 real none");
  endtask

  task automatic t_prio();
    rm_is_mem = 1; lock_pfx = 1; umip = 1; cpl = 3; seg_null = 1; page_fault = 1;
    want_exc("R12 ud first", 3'd1);
    rm_is_mem = 1; umip = 1; cpl = 3; seg_limit_stack = 1; page_fault = 1;
    want_exc("R12 priv over ss", 3'd2);
    rm_is_mem = 1; seg_limit_stack = 1; page_fault = 1; ac_en = 1; misaligned = 1; cpl = 3;
    want_exc("R12 ss over pf", 3'd3);
    rm_is_mem = 1; page_fault = 1; ac_en = 1; misaligned = 1; cpl = 3;
    want_exc("R12 pf over ac", 3'd4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_nohit();
    t_mem();
    t_regs();
    t_lock();
    t_umip();
    t_seg();
    t_pf();
    t_ac();
    t_prio();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule